// File: doc/BRIEF.md
# Multi-Source Jitter Sampler with Pair-XOR Whitening and Capture Buffer

This block turns a bank of free-running oscillator signals into a stream of random bits and keeps a record of that stream for later extraction. Every oscillator input goes through its own two-stage synchronizer. A dedicated capture flop then holds it, and that flop loads only when the sample strobe is high. The strobe is an irregular enable pulse, one system clock wide, that comes from a non-periodic source. The captured bits are folded into a single raw bit for each strobe by an exclusive-OR reduction.

A whitening stage takes raw bits two at a time and emits their exclusive-OR as one output bit, so the output rate is half the strobe rate. Each output bit is presented on a valid-qualified port. The output bits are also packed least-significant-bit first into words and written to an on-chip buffer at rising addresses. When the last address has been written the buffer stops and raises a full flag. A host reads the buffer through a registered read port, then restarts capture with a synchronous clear.

The design is built for source counts such as 5, 10 or 25, with one ring of three inverters behind each source. Strobes are expected no more often than once in 42 system clocks at 200 MHz. The pipeline also accepts strobes on back-to-back cycles.

Top module: `jitter_capture_top`

## Requirements
- R1: Each oscillator input has its own capture flop, which loads only in a cycle where `sample_stb` is high. The capture flops never share a sampler.
- R2: For every strobe, one raw bit is formed as the XOR of all N_SRC captured bits, two clock edges after the strobe edge.
- R3: Output bit k is the XOR of raw bits 2k and 2k+1, counted from reset or clear. `rnd_valid` is high for exactly one cycle per pair and is never high on two consecutive cycles.
- R4: `rnd_valid` rises at the third clock edge after the edge that samples the second strobe of a pair. It stays low after the first strobe of a pair.
- R5: Output bits are packed into WORD_W-bit words with the first bit of a word at bit 0 and each later bit at the next higher position.
- R6: Completed words are written to the buffer at addresses 0, 1, 2, … in order.
- R7: `buf_full` goes high once the word at address DEPTH-1 has been written. After that, further words are discarded and the buffer contents do not change.
- R8: A one-cycle `cap_clr` sets the write address back to 0 and drops `buf_full`. It also discards any half-formed pair and any partly packed word.
- R9: `rd_data` shows the buffer word at `rd_addr` one clock edge after the address is presented.
- R10: After reset, `rnd_valid` and `buf_full` are low.
- R11: A level change on an oscillator input reaches the capture flops only after two clock edges. A strobe sampled at the first or second edge after the change still captures the previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | N_SRC | Asynchronous oscillator bits, one per source |
| sample_stb | input | 1 | Sample enable pulse, one clock wide per event |
| cap_clr | input | 1 | Synchronous restart of pairing, packing and buffer fill |
| rnd_bit | output | 1 | Whitened random bit |
| rnd_valid | output | 1 | One-cycle qualifier for `rnd_bit` |
| buf_full | output | 1 | Buffer has reached its last address |
| rd_addr | input | $clog2(DEPTH) | Buffer read address |
| rd_data | output | WORD_W | Registered buffer read data |

## Verification
The bench builds the block with 5 sources, 8-bit words and a 4-word buffer. With five sources, all 32 oscillator patterns can be swept in one pass. With words and buffer this small, 16 strobes complete a word and under 150 strobes fill the buffer, so several complete fills are within reach. Reaching the full state, overrunning it, clearing in the middle of a word and refilling all fit in a few thousand cycles. A back-to-back strobe pair issued right after an input change shows whether the synchronizer depth is correct.

// File: rtl/jitter_capture_pkg.sv
package jitter_capture_pkg;
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/src_capture_bank.sv
module src_capture_bank #(
  parameter int unsigned N_SRC     = 5,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] osc_in,
  input  logic             sample_stb,
  output logic [N_SRC-1:0] cap_bits,
  output logic             cap_vld
);
  // one synchronizer chain and one capture flop per source
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [SYNC_DEPTH-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain       <= '0;
        cap_bits[g] <= 1'b0;
      end else begin
        chain <= {chain[SYNC_DEPTH-2:0], osc_in[g]};
        if (sample_stb) cap_bits[g] <= chain[SYNC_DEPTH-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cap_vld <= 1'b0;
    else     cap_vld <= sample_stb;
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> $stable(cap_bits)); // R1
endmodule

// File: rtl/xor_fold.sv
module xor_fold #(
  parameter int unsigned N_SRC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] cap_bits,
  input  logic             cap_vld,
  output logic             raw_bit,
  output logic             raw_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_bit <= 1'b0;
      raw_vld <= 1'b0;
    end else begin
      raw_vld <= cap_vld;
      if (cap_vld) raw_bit <= ^cap_bits;
    end
  end
endmodule

// File: rtl/pair_whitener.sv
module pair_whitener (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic raw_bit,
  input  logic raw_vld,
  output logic out_bit,
  output logic out_vld
);
  logic have_first;
  logic first_bit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      have_first <= 1'b0;
      first_bit  <= 1'b0;
      out_bit    <= 1'b0;
      out_vld    <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      if (raw_vld) begin
        if (!have_first) begin
          have_first <= 1'b1;
          first_bit  <= raw_bit;
        end else begin
          have_first <= 1'b0;
          out_bit    <= first_bit ^ raw_bit;
          out_vld    <= 1'b1;
        end
      end
    end
  end

  AST_OUT_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(raw_vld)); // R3
  AST_OUT_NOT_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld); // R3
endmodule

// File: rtl/word_packer.sv
module word_packer #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  pos;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_nxt;

  always_comb begin
    acc_nxt      = acc;
    acc_nxt[pos] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos      <= '0;
      acc      <= '0;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (bit_vld) begin
        acc <= acc_nxt;
        if (pos == LAST_POS) begin
          pos      <= '0;
          word_out <= acc_nxt;
          word_vld <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  AST_WORD_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(bit_vld)); // R5
endmodule

// File: rtl/capture_buffer.sv
module capture_buffer #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_vld,
  output logic              full,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wptr;
  logic              wr_en;

  assign wr_en = wr_vld && !full && !clr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      full <= 1'b0;
    end else if (wr_en) begin
      if (wptr == LAST_ADDR) full <= 1'b1;
      else                   wptr <= wptr + 1'b1;
    end
  end

  AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (full && !clr) |=> (full && $stable(wptr))); // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && !full && !clr) |=> (full || (wptr == $past(wptr) + 1'b1))); // R6
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!full && wptr == '0)); // R8
endmodule

// File: rtl/jitter_capture_top.sv
module jitter_capture_top
  import jitter_capture_pkg::*;
#(
  parameter int unsigned N_SRC  = 5,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned ADDR_W = addr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  osc_in,
  input  logic              sample_stb,
  input  logic              cap_clr,
  output logic              rnd_bit,
  output logic              rnd_valid,
  output logic              buf_full,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [N_SRC-1:0]  cap_bits;
  logic              cap_vld;
  logic              raw_bit;
  logic              raw_vld;
  logic [WORD_W-1:0] word_q;
  logic              word_vld;

  src_capture_bank #(.N_SRC(N_SRC), .SYNC_DEPTH(2)) u_bank (
    .clk(clk), .rst(rst), .osc_in(osc_in), .sample_stb(sample_stb),
    .cap_bits(cap_bits), .cap_vld(cap_vld));

  xor_fold #(.N_SRC(N_SRC)) u_fold (
    .clk(clk), .rst(rst), .cap_bits(cap_bits), .cap_vld(cap_vld),
    .raw_bit(raw_bit), .raw_vld(raw_vld));

  pair_whitener u_white (
    .clk(clk), .rst(rst), .clr(cap_clr), .raw_bit(raw_bit), .raw_vld(raw_vld),
    .out_bit(rnd_bit), .out_vld(rnd_valid));

  word_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .clr(cap_clr), .bit_in(rnd_bit), .bit_vld(rnd_valid),
    .word_out(word_q), .word_vld(word_vld));

  capture_buffer #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst(rst), .clr(cap_clr), .wr_data(word_q), .wr_vld(word_vld),
    .full(buf_full), .rd_addr(rd_addr), .rd_data(rd_data));

  AST_RAW_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> ##1 raw_vld); // R2
  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> $past(raw_vld)); // R4
endmodule

// File: tb/jitter_capture_top_tb_top.sv
module jitter_capture_top_tb_top;
  localparam int N = 5;
  localparam int W = 8;
  localparam int D = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] osc_in = '0;
  logic sample_stb = 1'b0;
  logic cap_clr = 1'b0;
  logic rnd_bit, rnd_valid, buf_full;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit have_m = 1'b0;
  bit first_m = 1'b0;
  int bcnt_m = 0;
  logic [W-1:0] acc_m = '0;
  int wp_m = 0;
  bit full_m = 1'b0;
  logic [W-1:0] exp_word [D];

  always #2.5 clk = ~clk;

  jitter_capture_top #(.N_SRC(N), .WORD_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .osc_in(osc_in), .sample_stb(sample_stb),
    .cap_clr(cap_clr), .rnd_bit(rnd_bit), .rnd_valid(rnd_valid),
    .buf_full(buf_full), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_bit(input bit b);
    acc_m[bcnt_m] = b;
    bcnt_m++;
    if (bcnt_m == W) begin
      if (!full_m) begin
        exp_word[wp_m] = acc_m;
        if (wp_m == D - 1) full_m = 1'b1;
        else wp_m++;
      end
      bcnt_m = 0;
    end
  endtask

  task automatic strobe_event(input logic [N-1:0] pat);
    bit raw, eb, ev;
    osc_in = pat;
    repeat (3) @(negedge clk);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    raw = ^pat;
    ev = 1'b0;
    eb = 1'b0;
    if (!have_m) begin
      have_m = 1'b1;
      first_m = raw;
    end else begin
      have_m = 1'b0;
      eb = first_m ^ raw;
      ev = 1'b1;
    end
    @(negedge clk);
    check(rnd_valid == 1'b0, "R4 early valid", int'(rnd_valid), 0);
    @(negedge clk);
    check(rnd_valid == ev, "R4 valid timing", int'(rnd_valid), int'(ev));
    if (ev) begin
      check(rnd_bit == eb, "R2/R3 pair xor bit", int'(rnd_bit), int'(eb));
      push_bit(eb);
    end
    @(negedge clk);
    check(rnd_valid == 1'b0, "R3 single-cycle valid", int'(rnd_valid), 0);
    repeat (34) @(negedge clk);
    check(buf_full == full_m, "R7 full flag", int'(buf_full), int'(full_m));
  endtask

  task automatic read_word(input int a, input string req);
    rd_addr = AW'(a);
    @(negedge clk);
    check(rd_data == exp_word[a], req, int'(rd_data), int'(exp_word[a]));
  endtask

  initial begin
    for (int i = 0; i < D; i++) exp_word[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rnd_valid == 1'b0, "R10 reset valid", int'(rnd_valid), 0);
    check(buf_full == 1'b0, "R10 reset full", int'(buf_full), 0);

    // R11: two back-to-back strobes right after an input change both see the old level
    osc_in = 5'b00001;
    repeat (5) @(negedge clk);
    osc_in = 5'b00011;
    sample_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sample_stb = 1'b0;
    @(negedge clk);
    check(rnd_valid == 1'b0, "R11 no early out", int'(rnd_valid), 0);
    @(negedge clk);
    check(rnd_valid == 1'b1, "R11 pair valid", int'(rnd_valid), 1);
    check(rnd_bit == 1'b0, "R11 sync depth", int'(rnd_bit), 0);
    push_bit(1'b0);
    repeat (40) @(negedge clk);

    // R1/R2: exhaustive sweep of all source patterns, then scrambled ones until overrun
    for (int i = 0; i < 32; i++) strobe_event(N'(i));
    for (int i = 0; i < 130; i++) strobe_event(N'((i * 13 + 7) & 31));
    check(buf_full == 1'b1, "R7 full reached", int'(buf_full), 1);

    for (int a = 0; a < D; a++) read_word(a, "R5/R6/R9 stored word");

    // R8: clear in the middle of a pair and a word
    for (int i = 0; i < 7; i++) strobe_event(N'((i * 5 + 3) & 31));
    @(negedge clk);
    cap_clr = 1'b1;
    @(negedge clk);
    cap_clr = 1'b0;
    have_m = 1'b0;
    bcnt_m = 0;
    wp_m = 0;
    full_m = 1'b0;
    @(negedge clk);
    check(buf_full == 1'b0, "R8 full dropped", int'(buf_full), 0);
    for (int i = 0; i < 16; i++) strobe_event(N'((i * 9 + 1) & 31));
    check(buf_full == 1'b0, "R8 one word not full", int'(buf_full), 0);
    read_word(0, "R8 refill word 0");
    read_word(1, "R7 old word kept");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule